// File: doc/BRIEF.md
# DDR On-Die Termination Enable Generator

This block produces the on-die termination (ODT) enable for each chip select of a DRAM interface. Each cycle the command scheduler presents the access type (read, write or something else), the chip select it targets, and a flag that marks the cycles in which that access moves data. Every chip select has its own 2-bit switch setting and its own read-enable and write-enable bits. Together these decide which accesses count as termination-worthy for that rank. A single memory-type input marks the low-power DRAM family, which has no termination, and it overrides all other settings.

Qualifying data cycles are delayed by a fixed lookahead of `MAX_LEAD` cycles, which stands for the moment the data reaches the bus. The ODT window then opens up to `lead_cfg` cycles before that moment and closes `lag_cfg` cycles after it. Windows that touch or overlap merge into one continuous high level. All outputs are registered and clear on reset.

Top module: `odt_gen`

## Requirements
- R1: While `rst_n` is low, and on the outputs after the first edge following its release with no traffic, every `odt` bit is 0. A reset also discards qualifying cycles that are already in flight.
- R2: A chip select whose switch setting is 0 (off) or 3 (reserved, handled as off) never drives its `odt` bit, whatever traffic it receives.
- R3: With switch setting 1, every data cycle of a read (`cmd_type`=1) or write (`cmd_type`=2) to that chip select qualifies. Types 0 and 3 never qualify.
- R4: With switch setting 2, a read qualifies only when that chip select's `rd_en` bit is 1, and a write qualifies only when its `wr_en` bit is 1.
- R5: A cycle qualifies only for the chip select whose number equals `cmd_cs`. Chip select i uses `sw_mode[2i+1:2i]`, `rd_en[i]`, `wr_en[i]` and drives `odt[i]`. No other `odt` bit reacts.
- R6: When `lp_mem` is 1 at an edge, every `odt` bit after that edge is 0, and that cycle's command never qualifies. Qualifying cycles from earlier edges take effect again once `lp_mem` returns to 0.
- R7: A qualifying cycle sampled at edge c drives `odt` high on the outputs after edges c+MAX_LEAD-lead_cfg through c+MAX_LEAD+lag_cfg inclusive, and it has no effect outside that range.
- R8: When the windows of successive qualifying cycles to one chip select touch or overlap, `odt` stays high across the whole span with no low cycle between them.
- R9: A cycle with `burst_act` low never qualifies, whatever its type, target or setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_mem | input | 1 | 1 when the attached memory is the low-power type without termination |
| sw_mode | input | 2*NUM_CS | Per chip select switch setting: 0 off, 1 all reads and writes, 2 selected by enables, 3 reserved |
| rd_en | input | NUM_CS | Per chip select read qualification for setting 2 |
| wr_en | input | NUM_CS | Per chip select write qualification for setting 2 |
| cmd_type | input | 2 | Access type this cycle: 0 other, 1 read, 2 write, 3 other |
| cmd_cs | input | CS_W | Chip select targeted this cycle |
| burst_act | input | 1 | 1 in each cycle that moves data for the current access |
| lead_cfg | input | LEAD_W | Cycles the window opens ahead of the data reference point (0..MAX_LEAD) |
| lag_cfg | input | LAG_W | Cycles the window stays open after the data reference point (0..MAX_LAG) |
| odt | output | NUM_CS | Registered termination enable, one bit per chip select |

## Verification
The bench sweeps every lead and lag combination for a single data cycle. This exposes an off-by-one in the window, which would show as ODT opening or closing one cycle early or late. It drives back-to-back data cycles and data cycles one idle cycle apart with a lag that makes their windows meet. A design that rebuilt its window from the newest cycle alone would drop low for a cycle between them. It raises the low-power flag in the middle of an open window. A design that cleared its history there would stay low afterwards, and one that ignored the flag would keep driving. Further vectors cover setting 3, setting 2 with the enable for the other access type, and a reset with traffic in flight. These catch a decoder that maps the reserved code to an active mode, one that swaps the two enables, and one that leaves stale qualifying cycles in its history.

// File: rtl/odt_pkg.sv
`timescale 1ns/1ps
package odt_pkg;

   typedef enum logic [1:0] {
      CMD_OTHER = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2,
      CMD_SPARE = 2'd3
   } cmd_e;

   typedef enum logic [1:0] {
      SW_OFF  = 2'd0,
      SW_ALL  = 2'd1,
      SW_SEL  = 2'd2,
      SW_RSVD = 2'd3
   } sw_mode_e;

   typedef struct packed {
      logic rd;
      logic wr;
   } access_t;

   function automatic access_t classify(input logic [1:0] t);
      access_t a;
      a.rd = (t == CMD_READ);
      a.wr = (t == CMD_WRITE);
      return a;
   endfunction

endpackage

// File: rtl/odt_cs_decode.sv
`timescale 1ns/1ps
module odt_cs_decode #(
   parameter int NUM_CS = 2,
   parameter int CS_W   = 1
) (
   input  logic [CS_W-1:0]   cmd_cs,
   input  logic              burst_act,
   input  logic              lp_mem,
   output logic [NUM_CS-1:0] hit
);

   logic live;
   assign live = burst_act & ~lp_mem;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign hit[i] = live & (cmd_cs == CS_W'(i));
   end

endmodule

// File: rtl/odt_mode_qual.sv
`timescale 1ns/1ps
module odt_mode_qual
   import odt_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       rd_en,
   input  logic       wr_en,
   input  access_t    acc,
   input  logic       hit,
   output logic       qual
);

   logic allow;

   always_comb begin
      unique case (sw_mode_e'(mode))
         SW_ALL:  allow = acc.rd | acc.wr;
         SW_SEL:  allow = (acc.rd & rd_en) | (acc.wr & wr_en);
         SW_OFF:  allow = 1'b0;
         default: allow = 1'b0;
      endcase
   end

   assign qual = hit & allow;

endmodule

// File: rtl/odt_window.sv
`timescale 1ns/1ps
module odt_window #(
   parameter int MAX_LEAD = 3,
   parameter int MAX_LAG  = 3,
   localparam int LEAD_W  = $clog2(MAX_LEAD + 1),
   localparam int LAG_W   = $clog2(MAX_LAG + 1),
   localparam int TAPS    = MAX_LEAD + MAX_LAG + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qual,
   input  logic              block,
   input  logic [LEAD_W-1:0] lead_cfg,
   input  logic [LAG_W-1:0]  lag_cfg,
   output logic              odt
);

   logic [TAPS-1:0] tap;
   logic [TAPS-2:0] hist;
   logic [TAPS-1:0] in_win;
   int              lead_eff;
   int              lag_eff;

   always_comb begin
      lead_eff = (int'(lead_cfg) > MAX_LEAD) ? MAX_LEAD : int'(lead_cfg);
      lag_eff  = (int'(lag_cfg)  > MAX_LAG)  ? MAX_LAG  : int'(lag_cfg);
   end

   assign tap[0]        = qual;
   assign tap[TAPS-1:1] = hist;

   always_ff @(posedge clk) begin
      if (!rst_n) hist <= '0;
      else        hist <= tap[TAPS-2:0];
   end

   for (genvar j = 0; j < TAPS; j++) begin : g_tap
      assign in_win[j] = tap[j]
                       & ((j + lead_eff) >= MAX_LEAD)
                       & (j <= (MAX_LEAD + lag_eff));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) odt <= 1'b0;
      else        odt <= ~block & (|in_win);
   end

endmodule

// File: rtl/odt_gen.sv
`timescale 1ns/1ps
module odt_gen
   import odt_pkg::*;
#(
   parameter int NUM_CS   = 2,
   parameter int MAX_LEAD = 3,
   parameter int MAX_LAG  = 3,
   localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int LEAD_W  = $clog2(MAX_LEAD + 1),
   localparam int LAG_W   = $clog2(MAX_LAG + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lp_mem,
   input  logic [2*NUM_CS-1:0] sw_mode,
   input  logic [NUM_CS-1:0]   rd_en,
   input  logic [NUM_CS-1:0]   wr_en,
   input  logic [1:0]          cmd_type,
   input  logic [CS_W-1:0]     cmd_cs,
   input  logic                burst_act,
   input  logic [LEAD_W-1:0]   lead_cfg,
   input  logic [LAG_W-1:0]    lag_cfg,
   output logic [NUM_CS-1:0]   odt
);

   if (NUM_CS < 1 || NUM_CS > 16) begin : g_bad_cs
      $error("odt_gen: NUM_CS must lie in 1..16");
   end
   if (MAX_LEAD < 1 || MAX_LEAD > 15) begin : g_bad_lead
      $error("odt_gen: MAX_LEAD must lie in 1..15");
   end
   if (MAX_LAG < 1 || MAX_LAG > 15) begin : g_bad_lag
      $error("odt_gen: MAX_LAG must lie in 1..15");
   end

   access_t           acc;
   logic [NUM_CS-1:0] hit;
   logic [NUM_CS-1:0] qual;

   assign acc = classify(cmd_type);

   odt_cs_decode #(
      .NUM_CS (NUM_CS),
      .CS_W   (CS_W)
   ) u_dec (
      .cmd_cs    (cmd_cs),
      .burst_act (burst_act),
      .lp_mem    (lp_mem),
      .hit       (hit)
   );

   for (genvar i = 0; i < NUM_CS; i++) begin : g_rank
      odt_mode_qual u_qual (
         .mode  (sw_mode[2*i +: 2]),
         .rd_en (rd_en[i]),
         .wr_en (wr_en[i]),
         .acc   (acc),
         .hit   (hit[i]),
         .qual  (qual[i])
      );

      odt_window #(
         .MAX_LEAD (MAX_LEAD),
         .MAX_LAG  (MAX_LAG)
      ) u_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .qual     (qual[i]),
         .block    (lp_mem),
         .lead_cfg (lead_cfg),
         .lag_cfg  (lag_cfg),
         .odt      (odt[i])
      );
   end

endmodule

// File: rtl/odt_gen_chk.sv
`timescale 1ns/1ps
module odt_gen_chk #(
   parameter int NUM_CS   = 2,
   parameter int MAX_LEAD = 3,
   parameter int MAX_LAG  = 3,
   localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int WIN     = MAX_LEAD + MAX_LAG + 1,
   localparam int CNT_W   = $clog2(WIN + 2)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                lp_mem,
   input logic [2*NUM_CS-1:0] sw_mode,
   input logic [NUM_CS-1:0]   rd_en,
   input logic [NUM_CS-1:0]   wr_en,
   input logic [1:0]          cmd_type,
   input logic [CS_W-1:0]     cmd_cs,
   input logic                burst_act,
   input logic [NUM_CS-1:0]   odt
);

   logic lp_d;
   always_ff @(posedge clk) begin
      if (!rst_n) lp_d <= 1'b0;
      else        lp_d <= lp_mem;
   end

   // R6: low-power memory clears every enable on the next output
   p_lp_forces_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lp_mem |=> (odt == '0));

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      logic                rd_c, wr_c, mode_off, wants, tgt;
      logic [MAX_LEAD:0]   pipe;
      logic [CNT_W-1:0]    off_cnt;
      logic [CNT_W-1:0]    idle_cnt;

      assign rd_c     = (cmd_type == 2'd1);
      assign wr_c     = (cmd_type == 2'd2);
      assign mode_off = (sw_mode[2*i +: 2] == 2'd0) || (sw_mode[2*i +: 2] == 2'd3);
      assign tgt      = burst_act && !lp_mem && (cmd_cs == CS_W'(i));
      assign wants    = tgt && (((sw_mode[2*i +: 2] == 2'd1) && (rd_c || wr_c)) ||
                                ((sw_mode[2*i +: 2] == 2'd2) &&
                                 ((rd_c && rd_en[i]) || (wr_c && wr_en[i]))));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pipe     <= '0;
            off_cnt  <= '0;
            idle_cnt <= '0;
         end else begin
            pipe <= {pipe[MAX_LEAD-1:0], wants};
            if (!mode_off)                    off_cnt <= '0;
            else if (off_cnt < CNT_W'(WIN+1)) off_cnt <= off_cnt + 1'b1;
            if (wants)                         idle_cnt <= '0;
            else if (idle_cnt < CNT_W'(WIN+1)) idle_cnt <= idle_cnt + 1'b1;
         end
      end

      // R7: the data reference point of a qualifying cycle is always covered
      p_ref_point_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (pipe[MAX_LEAD] && !lp_d) |-> odt[i]);

      // R2: a rank held off long enough shows no termination
      p_off_mode_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (off_cnt >= CNT_W'(WIN)) |-> !odt[i]);

      // R4: with no qualifying cycle in the window the enable stays low
      p_no_cause_no_odt_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (idle_cnt >= CNT_W'(WIN)) |-> !odt[i]);
   end

endmodule

bind odt_gen odt_gen_chk #(
   .NUM_CS   (NUM_CS),
   .MAX_LEAD (MAX_LEAD),
   .MAX_LAG  (MAX_LAG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lp_mem    (lp_mem),
   .sw_mode   (sw_mode),
   .rd_en     (rd_en),
   .wr_en     (wr_en),
   .cmd_type  (cmd_type),
   .cmd_cs    (cmd_cs),
   .burst_act (burst_act),
   .odt       (odt)
);

// File: tb/tb_odt_gen.sv
`timescale 1ns/1ps
module tb_odt_gen;

   localparam int D = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lp_mem = 1'b0;
   logic [3:0] sw_mode = 4'b0;
   logic [1:0] rd_en = 2'b0;
   logic [1:0] wr_en = 2'b0;
   logic [1:0] cmd_type = 2'b0;
   logic       cmd_cs = 1'b0;
   logic       burst_act = 1'b0;
   logic [1:0] lead_cfg = 2'd0;
   logic [1:0] lag_cfg = 2'd0;
   logic [1:0] odt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   odt_gen dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .lp_mem    (lp_mem),
      .sw_mode   (sw_mode),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .cmd_type  (cmd_type),
      .cmd_cs    (cmd_cs),
      .burst_act (burst_act),
      .lead_cfg  (lead_cfg),
      .lag_cfg   (lag_cfg),
      .odt       (odt)
   );

   typedef struct packed {
      logic       lp;
      logic [3:0] mode;
      logic [1:0] rde;
      logic [1:0] wre;
      logic [1:0] typ;
      logic       cs;
      logic       burst;
      logic [1:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'b0101, 2'b00, 2'b00, 2'd1, 1'b0, 1'b1, 2'b01, 4'd3}, // R3 read
      '{1'b0, 4'b0101, 2'b00, 2'b00, 2'd2, 1'b1, 1'b1, 2'b10, 4'd5}, // R5 write cs1
      '{1'b0, 4'b0101, 2'b00, 2'b00, 2'd0, 1'b0, 1'b1, 2'b00, 4'd3}, // R3 other type
      '{1'b0, 4'b0101, 2'b00, 2'b00, 2'd3, 1'b1, 1'b1, 2'b00, 4'd3}, // R3 spare type
      '{1'b0, 4'b0101, 2'b00, 2'b00, 2'd1, 1'b0, 1'b0, 2'b00, 4'd9}, // R9 no burst
      '{1'b0, 4'b0100, 2'b00, 2'b00, 2'd1, 1'b0, 1'b1, 2'b00, 4'd2}, // R2 mode 0
      '{1'b0, 4'b1101, 2'b00, 2'b00, 2'd2, 1'b1, 1'b1, 2'b00, 4'd2}, // R2 mode 3
      '{1'b0, 4'b0010, 2'b01, 2'b00, 2'd1, 1'b0, 1'b1, 2'b01, 4'd4}, // R4 read enabled
      '{1'b0, 4'b0010, 2'b00, 2'b01, 2'd1, 1'b0, 1'b1, 2'b00, 4'd4}, // R4 read masked
      '{1'b0, 4'b0010, 2'b00, 2'b01, 2'd2, 1'b0, 1'b1, 2'b01, 4'd4}, // R4 write enabled
      '{1'b0, 4'b1000, 2'b10, 2'b00, 2'd2, 1'b1, 1'b1, 2'b00, 4'd4}, // R4 write masked
      '{1'b0, 4'b1000, 2'b10, 2'b00, 2'd1, 1'b1, 1'b1, 2'b10, 4'd4}, // R4 cs1 read
      '{1'b1, 4'b0101, 2'b00, 2'b00, 2'd1, 1'b0, 1'b1, 2'b00, 4'd6}, // R6 low-power
      '{1'b0, 4'b0001, 2'b00, 2'b00, 2'd2, 1'b1, 1'b1, 2'b00, 4'd5}, // R5 other rank off
      '{1'b0, 4'b0101, 2'b00, 2'b00, 2'd1, 1'b1, 1'b1, 2'b10, 4'd5}  // R5 read cs1
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input logic [1:0] got, input logic [1:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s odt actual=%b expected=%b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic idle();
      burst_act = 1'b0;
      cmd_type  = 2'd0;
      lp_mem    = 1'b0;
   endtask

   // Sequence on one rank with both ranks in setting 1; expected values from R7 windows
   task automatic burst_seq(input int cs_i, input logic [1:0] typ, input logic [7:0] pat,
                            input logic [15:0] lpm, input int L, input int G, input string tag);
      int n;
      n = 8 + D + G + 2;
      sw_mode  = 4'b0101;
      lead_cfg = 2'(L);
      lag_cfg  = 2'(G);
      cmd_cs   = 1'(cs_i);
      cmd_type = typ;
      for (int k = 0; k < n; k++) begin
         logic e;
         logic [1:0] ev;
         burst_act = (k < 8) ? pat[k] : 1'b0;
         lp_mem    = (k < 16) ? lpm[k] : 1'b0;
         tick();
         e = 1'b0;
         for (int m = 0; m < 8; m++) begin
            if (pat[m] && !lpm[m] && (k - m) >= (D - L) && (k - m) <= (D + G)) e = 1'b1;
         end
         if (lpm[k]) e = 1'b0;
         ev = (cs_i == 0) ? {1'b0, e} : {e, 1'b0};
         check(odt, ev, tag);
      end
      idle();
      repeat (D + 4) tick();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R1: outputs held low in reset even with qualifying traffic
      sw_mode = 4'b0101; cmd_type = 2'd1; burst_act = 1'b1;
      repeat (3) tick();
      check(odt, 2'b00, "R1 in reset");
      idle();
      rst_n = 1'b1;
      tick();
      check(odt, 2'b00, "R1 after release");

      // Table walk: one cycle of stimulus, sample at the data reference point
      for (int v = 0; v < NV; v++) begin
         lead_cfg  = 2'd0;
         lag_cfg   = 2'd0;
         sw_mode   = VECS[v].mode;
         rd_en     = VECS[v].rde;
         wr_en     = VECS[v].wre;
         cmd_type  = VECS[v].typ;
         cmd_cs    = VECS[v].cs;
         burst_act = VECS[v].burst;
         lp_mem    = VECS[v].lp;
         tick();
         idle();
         repeat (D) tick();
         checks++;
         if (odt !== VECS[v].exp) begin
            errors++;
            $display("FAIL R%0d vector %0d odt actual=%b expected=%b",
                     VECS[v].req, v, odt, VECS[v].exp);
         end
         tick();
      end
      rd_en = 2'b00;
      wr_en = 2'b00;

      // R7: every lead and lag combination for a single read
      for (int L = 0; L < 4; L++) begin
         for (int G = 0; G < 4; G++) begin
            burst_seq(0, 2'd1, 8'b0000_0001, 16'h0, L, G, "R7 window");
         end
      end
      burst_seq(1, 2'd2, 8'b0000_0001, 16'h0, 2, 1, "R5 window cs1");

      // R8: adjacent and touching windows merge without a low cycle
      burst_seq(0, 2'd1, 8'b0000_0011, 16'h0, 0, 0, "R8 back-to-back");
      burst_seq(1, 2'd2, 8'b0000_0101, 16'h0, 0, 1, "R8 touching windows");
      burst_seq(0, 2'd2, 8'b0001_0001, 16'h0, 2, 2, "R8 overlapping windows");

      // R6: low-power flag in the middle of an open window
      burst_seq(0, 2'd1, 8'b0000_0001, 16'h1 << (D + 1), 0, 3, "R6 mid-window");

      // R1: reset with a qualifying cycle in flight discards it
      sw_mode = 4'b0101; lead_cfg = 2'd0; lag_cfg = 2'd3;
      cmd_cs = 1'b0; cmd_type = 2'd1; burst_act = 1'b1;
      tick();
      idle();
      tick();
      rst_n = 1'b0;
      tick();
      check(odt, 2'b00, "R1 reset in flight");
      rst_n = 1'b1;
      for (int k = 0; k < D + 4; k++) begin
         tick();
         check(odt, 2'b00, "R1 history cleared");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule